// File: doc/BRIEF.md
# Local Tick Timer

One timer instance per processor core, built from two down-counters in series. The first counter is a programmable prescaler. It turns the input clock into a tick pulse once every (tick reload + 1) cycles. The second counter counts those ticks. When its count runs out, it latches an interrupt status flag. Software then either lets it reload and run again (interval mode) or lets it stop after the single event (one-shot mode).

Software reaches the block over a simple 32-bit register bus. Each instance answers only inside its own 256-byte window. The window starts at 0x300 plus 0x100 times the instance index. Every write to a reload value or to the control word sets a matching bit in a write-acknowledge register, which software clears by writing 1. The running interrupt counter takes a new count only when the write carries the force-load flag in bit 31.

Top module: `local_tick_timer`

## Requirements
- R1: After reset, every register reads 0 and irq_o is low.
- R2: While control bit 0 (tick run) is set, the prescaler emits one tick every TICK+1 clock cycles, where TICK is the value at offset 0x00.
- R3: With control bits 0 and 1 set (value 3), the status flag sets on the edge N·(TICK+1) edges after the edge that takes the control write. N is the running count, and a count of 0 behaves as 1.
- R4: A write to offset 0x08 always stores bits 30:0 as the reload value. It changes the running count only when bit 31 is 1. Without bit 31, the new value applies from the next reload onward.
- R5: With control bit 2 set (interval mode), the counter reloads on expiry, so the status flag sets again every N·(TICK+1) edges.
- R6: Without interval mode, expiry clears control bit 1 (bit 0 stays), and no further event occurs.
- R7: Status bit 0 at offset 0x30 stays set until a write of 1 to that bit; a write of 0 leaves it set.
- R8: irq_o is high exactly when status bit 0 and enable bit 0 (offset 0x34) are both set.
- R9: Write-acknowledge register 0x40: bit 0 sets on a write to 0x00, bit 1 on a write to 0x08, bit 3 on a write to 0x20; other writes leave it unchanged; writing 1 clears a bit.
- R10: A control write that clears bits 0 and 1 on the very edge where expiry would happen suppresses that expiry.
- R11: Accesses outside this instance's window are ignored and read as 0; registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle as the request |
| irq_o | output | 1 | Interrupt, level |

## Verification
The bench times the first event over random pairs of prescaler reload and count, including a reload of 0, in one-shot mode. A wrong prescaler period and a wrong count stage give distinct products, so each shows up on its own. Interval runs with a reload change that has no force-load flag separate "running count" from "stored reload" across two periods. Directed cases stop the timer on the exact expiry edge, mask the interrupt enable, and access a neighbouring instance's window. Each of these isolates one gating path.

// File: rtl/ltt_pkg.sv
package ltt_pkg;
  localparam int unsigned OFF_TICK  = 8'h00;
  localparam int unsigned OFF_ICNT  = 8'h08;
  localparam int unsigned OFF_CTRL  = 8'h20;
  localparam int unsigned OFF_STAT  = 8'h30;
  localparam int unsigned OFF_EN    = 8'h34;
  localparam int unsigned OFF_WSTAT = 8'h40;

  localparam int unsigned CTRL_TICK_RUN = 0;
  localparam int unsigned CTRL_ICNT_RUN = 1;
  localparam int unsigned CTRL_INTERVAL = 2;

  localparam int unsigned WS_TICK = 0;
  localparam int unsigned WS_ICNT = 1;
  localparam int unsigned WS_CTRL = 3;

  localparam int unsigned ICNT_FORCE_BIT = 31;
endpackage

// File: rtl/ltt_prescaler.sv
module ltt_prescaler #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] reload_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!run_i)     cnt_q <= reload_i;   // park at reload while halted
    else if (tick_o)     cnt_q <= reload_i;
    else                 cnt_q <= cnt_q - 1'b1;
  end

  a_r2_reload_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == $past(reload_i)));

  a_r2_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ltt_icount.sv
module ltt_icount #(
  parameter int unsigned W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  input  logic         force_i,
  input  logic [W-1:0] force_val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic         last;

  assign last     = (cnt_q <= W'(1));
  assign expire_o = run_i && tick_i && last && !force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (force_i)            cnt_q <= force_val_i;
    else if (expire_o)           cnt_q <= reload_i;
    else if (run_i && tick_i)    cnt_q <= cnt_q - 1'b1;
  end

  a_r3_tick_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !force_i && !expire_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

  a_r4_force_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> (cnt_q == $past(force_val_i)));

  a_r10_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !force_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ltt_regs.sv
module ltt_regs
  import ltt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned INST_IDX = 0,
  parameter int unsigned TICK_W   = 32,
  parameter int unsigned ICNT_W   = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              expire_i,
  output logic [TICK_W-1:0] tick_reload_o,
  output logic [ICNT_W-1:0] icnt_reload_o,
  output logic              icnt_force_o,
  output logic              tick_run_o,
  output logic              icnt_run_o,
  output logic              irq_o
);
  localparam int unsigned BASE     = 32'h300 + 32'h100 * INST_IDX;
  localparam int unsigned PAGE_W   = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(BASE >> 8);

  logic              hit;
  logic [7:0]        off;
  logic              wr_tick, wr_icnt, wr_ctrl, wr_stat, wr_en, wr_wstat;
  logic [TICK_W-1:0] tick_q;
  logic [ICNT_W-1:0] icnt_q;
  logic [2:0]        ctrl_q;
  logic              stat_q, en_q;
  logic [3:0]        wstat_q;

  assign hit = bus_req_i && (bus_addr_i[ADDR_W-1:8] == PAGE);
  assign off = bus_addr_i[7:0];

  assign wr_tick  = hit && bus_we_i && (off == 8'(OFF_TICK));
  assign wr_icnt  = hit && bus_we_i && (off == 8'(OFF_ICNT));
  assign wr_ctrl  = hit && bus_we_i && (off == 8'(OFF_CTRL));
  assign wr_stat  = hit && bus_we_i && (off == 8'(OFF_STAT));
  assign wr_en    = hit && bus_we_i && (off == 8'(OFF_EN));
  assign wr_wstat = hit && bus_we_i && (off == 8'(OFF_WSTAT));

  // a write that clears a run bit halts that stage on the same edge
  assign tick_run_o = ctrl_q[CTRL_TICK_RUN] && !(wr_ctrl && !bus_wdata_i[CTRL_TICK_RUN]);
  assign icnt_run_o = ctrl_q[CTRL_ICNT_RUN] && !(wr_ctrl && !bus_wdata_i[CTRL_ICNT_RUN]);

  assign tick_reload_o = tick_q;
  assign icnt_reload_o = icnt_q;
  assign icnt_force_o  = wr_icnt && bus_wdata_i[ICNT_FORCE_BIT];
  assign irq_o         = stat_q && en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= '0;
      icnt_q  <= '0;
      ctrl_q  <= '0;
      stat_q  <= 1'b0;
      en_q    <= 1'b0;
      wstat_q <= '0;
    end else begin
      if (wr_tick) tick_q <= bus_wdata_i[TICK_W-1:0];
      if (wr_icnt) icnt_q <= bus_wdata_i[ICNT_W-1:0];
      if (wr_en)   en_q   <= bus_wdata_i[0];

      if (wr_ctrl)
        ctrl_q <= bus_wdata_i[2:0];
      else if (expire_i && !ctrl_q[CTRL_INTERVAL])
        ctrl_q[CTRL_ICNT_RUN] <= 1'b0;

      if (expire_i)                     stat_q <= 1'b1;
      else if (wr_stat && bus_wdata_i[0]) stat_q <= 1'b0;

      if (wr_wstat) begin
        wstat_q[WS_TICK] <= wstat_q[WS_TICK] && !bus_wdata_i[WS_TICK];
        wstat_q[WS_ICNT] <= wstat_q[WS_ICNT] && !bus_wdata_i[WS_ICNT];
        wstat_q[WS_CTRL] <= wstat_q[WS_CTRL] && !bus_wdata_i[WS_CTRL];
      end else begin
        if (wr_tick) wstat_q[WS_TICK] <= 1'b1;
        if (wr_icnt) wstat_q[WS_ICNT] <= 1'b1;
        if (wr_ctrl) wstat_q[WS_CTRL] <= 1'b1;
      end
      wstat_q[2] <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit && !bus_we_i) begin
      case (off)
        8'(OFF_TICK):  bus_rdata_o = 32'(tick_q);
        8'(OFF_ICNT):  bus_rdata_o = 32'(icnt_q);
        8'(OFF_CTRL):  bus_rdata_o = 32'(ctrl_q);
        8'(OFF_STAT):  bus_rdata_o = 32'(stat_q);
        8'(OFF_EN):    bus_rdata_o = 32'(en_q);
        8'(OFF_WSTAT): bus_rdata_o = 32'(wstat_q);
        default:       bus_rdata_o = '0;
      endcase
    end
  end

  a_r6_oneshot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !ctrl_q[CTRL_INTERVAL] && !wr_ctrl) |=> !ctrl_q[CTRL_ICNT_RUN]);

  a_r7_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !(wr_stat && bus_wdata_i[0])) |=> stat_q);

  a_r9_ack_ctrl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> wstat_q[WS_CTRL]);

  a_r5_interval_keeps_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && ctrl_q[CTRL_INTERVAL] && !wr_ctrl) |=> ctrl_q[CTRL_ICNT_RUN]);
endmodule

// File: rtl/local_tick_timer.sv
module local_tick_timer #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned INST_IDX = 0,
  parameter int unsigned TICK_W   = 32,
  parameter int unsigned ICNT_W   = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  logic [TICK_W-1:0] tick_reload;
  logic [ICNT_W-1:0] icnt_reload;
  logic              icnt_force, tick_run, icnt_run, tick, expire;

  ltt_regs #(
    .ADDR_W(ADDR_W), .INST_IDX(INST_IDX), .TICK_W(TICK_W), .ICNT_W(ICNT_W)
  ) u_regs (
    .clk_i, .rst_ni, .bus_req_i, .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .expire_i(expire), .tick_reload_o(tick_reload), .icnt_reload_o(icnt_reload),
    .icnt_force_o(icnt_force), .tick_run_o(tick_run), .icnt_run_o(icnt_run), .irq_o
  );

  ltt_prescaler #(.W(TICK_W)) u_pre (
    .clk_i, .rst_ni, .run_i(tick_run), .reload_i(tick_reload), .tick_o(tick)
  );

  ltt_icount #(.W(ICNT_W)) u_icnt (
    .clk_i, .rst_ni, .run_i(icnt_run), .tick_i(tick), .reload_i(icnt_reload),
    .force_i(icnt_force), .force_val_i(bus_wdata_i[ICNT_W-1:0]), .expire_o(expire)
  );
endmodule

// File: tb/local_tick_timer_test.sv
module local_tick_timer_test;
  localparam int INST = 1;
  localparam logic [11:0] BASE = 12'h400;
  localparam logic [11:0] A_TICK = BASE + 12'h00, A_ICNT = BASE + 12'h08,
    A_CTRL = BASE + 12'h20, A_STAT = BASE + 12'h30, A_EN = BASE + 12'h34,
    A_WST = BASE + 12'h40;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  local_tick_timer #(.INST_IDX(INST)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int first_event(int t, int n);
    return ((n == 0) ? 1 : n) * (t + 1);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bw(logic [11:0] a, logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic br(logic [11:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_irq(inout int k, input int lim);
    while (!irq && k < lim) begin @(negedge clk); k++; end
  endtask

  initial begin
    #(5ns * 150000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k, e, t, n, s;
    s = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    foreach (A_LIST[i]) begin br(A_LIST[i], d); chk("R1 reg", d, 0); end

    // R2 prescaler period, N=1
    bw(A_TICK, 4); bw(A_ICNT, 32'h8000_0001); bw(A_EN, 1); bw(A_CTRL, 3);
    k = 0; wait_irq(k, 200);
    chk("R2 period", k, first_event(4, 1));
    bw(A_STAT, 1); bw(A_CTRL, 0);

    // R3 count 0 behaves as 1
    bw(A_TICK, 2); bw(A_ICNT, 32'h8000_0000); bw(A_CTRL, 3);
    k = 0; wait_irq(k, 200);
    chk("R3 zero count", k, first_event(2, 0));
    bw(A_STAT, 1); bw(A_CTRL, 0);

    // R3/R6 random one-shot runs
    for (int i = 0; i < 10; i++) begin
      t = $urandom_range(0, 5); n = $urandom_range(1, 6);
      bw(A_TICK, t); bw(A_ICNT, 32'h8000_0000 | n); bw(A_CTRL, 3);
      e = first_event(t, n);
      k = 0; wait_irq(k, 500);
      chk("R3 first event", k, e);
      br(A_CTRL, d); chk("R6 run bit cleared", d, 1);
      bw(A_STAT, 1);
      chk("R7 cleared irq", 32'(irq), 0);
      repeat (3 * e + 4) @(negedge clk);
      chk("R6 no re-fire", 32'(irq), 0);
      bw(A_CTRL, 0);
    end

    // R5 interval repeats
    bw(A_TICK, 2); bw(A_ICNT, 32'h8000_0003); bw(A_CTRL, 7);
    k = 0; wait_irq(k, 200);
    chk("R5 first", k, 9);
    bw(A_STAT, 1); k++;
    wait_irq(k, 200); chk("R5 second", k, 18);
    bw(A_STAT, 1); k++;
    wait_irq(k, 200); chk("R5 third", k, 27);
    bw(A_CTRL, 0); bw(A_STAT, 1);

    // R4 reload write without force flag affects only next period
    bw(A_TICK, 1); bw(A_ICNT, 32'h8000_0004); bw(A_CTRL, 7);
    bw(A_ICNT, 6); k = 1;
    wait_irq(k, 200); chk("R4 running count kept", k, 8);
    bw(A_STAT, 1); k++;
    wait_irq(k, 200); chk("R4 next period uses reload", k, 20);
    bw(A_CTRL, 0); bw(A_STAT, 1);
    br(A_ICNT, d); chk("R4 reload readback", d, 6);

    // R10 stop on the expiry edge
    bw(A_TICK, 2); bw(A_ICNT, 32'h8000_0002); bw(A_CTRL, 3);
    repeat (5) @(negedge clk);
    bw(A_CTRL, 0);
    chk("R10 irq", 32'(irq), 0);
    br(A_STAT, d); chk("R10 status", d, 0);
    repeat (20) @(negedge clk);
    chk("R10 later", 32'(irq), 0);

    // R8 enable gating, R7 write 0 ignored
    bw(A_EN, 0);
    bw(A_TICK, 0); bw(A_ICNT, 32'h8000_0002); bw(A_CTRL, 3);
    repeat (6) @(negedge clk);
    chk("R8 masked", 32'(irq), 0);
    br(A_STAT, d); chk("R8 status set", d, 1);
    bw(A_STAT, 0);
    br(A_STAT, d); chk("R7 write 0 keeps", d, 1);
    bw(A_EN, 1);
    chk("R8 unmasked", 32'(irq), 1);
    bw(A_STAT, 1); bw(A_CTRL, 0);
    chk("R7 clear", 32'(irq), 0);

    // R9 write acknowledge
    bw(A_WST, 32'hB);
    br(A_WST, d); chk("R9 cleared", d, 0);
    bw(A_TICK, 5);  br(A_WST, d); chk("R9 tick ack", d, 1);
    bw(A_ICNT, 3);  br(A_WST, d); chk("R9 icnt ack", d, 3);
    bw(A_CTRL, 0);  br(A_WST, d); chk("R9 ctrl ack", d, 32'hB);
    bw(A_EN, 0);    br(A_WST, d); chk("R9 other write", d, 32'hB);
    bw(A_WST, 2);   br(A_WST, d); chk("R9 w1c one bit", d, 32'h9);

    // R11 decode
    bw(12'h320, 7);
    br(A_CTRL, d); chk("R11 foreign write", d, 0);
    br(12'h300, d); chk("R11 foreign read", d, 0);
    br(A_TICK, d); chk("R11 readback tick", d, 5);
    br(A_ICNT, d); chk("R11 readback icnt", d, 3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  localparam logic [11:0] A_LIST [6] = '{A_TICK, A_ICNT, A_CTRL, A_STAT, A_EN, A_WST};
endmodule